// File: doc/BRIEF.md
# Clear-on-Read Ring Interrupt Controller

This block gathers completion events from a set of ring channels and turns them into one level interrupt for software. Each channel can report three kinds of event: transmit done, receive done and receive overflow. The events are latched into a flat pending vector. Software reads that vector through a set of 32-bit status words, and each word empties itself when it is read. A second set of words holds per-channel enable bits for the receive and transmit directions. A read-only capability word reports how many channels the block was built with.

A three-state re-arm machine controls the interrupt line. In `ST_ARMED` it waits for an enabled pending bit. It then moves to `ST_FIRE`, where the line is high. When software reads any status word, the machine drops to `ST_DRAIN`. It stays there, holding the line low, until every status word has been read at least once since the interrupt fired. This includes words whose channels are all masked. The `ST_FIRE` to `ST_ARMED` transition without any read happens only when masking removes the last enabled cause.

The register port is a plain single-cycle read/write strobe pair with a word address. Read data appears on the clock edge that follows the read strobe. Event inputs are one-cycle pulses, one bit per channel.

Top module: `ring_irq_ctrl`

## Requirements
- R1: After reset every pending bit and every enable bit is zero, `irq` is low, and the re-arm machine is in `ST_ARMED`.
- R2: Pending bit k of the flat vector is transmit channel k for k < N, receive channel k-N for N <= k < 2N, and receive-overflow channel k-2N for 2N <= k < 3N. Status word w (at word address `STAT_BASE`+w, w < (31+3N)/32) carries flat bits 32w to 32w+31. Bits at or beyond 3N read as zero, so a vector may span two words.
- R3: Reading a status word returns its contents on `reg_rdata` one cycle later and clears exactly that word's pending bits. All other words are untouched.
- R4: An event whose bit lies in a status word being read in the same cycle is not in the returned data, and it remains set afterwards.
- R5: Enable word e sits at word address `EN_BASE`+e, for e < (31+2N)/32. Flat enable bit j is the receive enable of channel j for j < N, and the transmit enable of channel j-N for N <= j < 2N. A write replaces the whole word. A read returns the stored bits, and bits at or beyond 2N read as zero.
- R6: The word at `CAP_ADDR` returns N in bits 10:0 and zero above. Writes to it or to status words change nothing. Unmapped addresses read as zero.
- R7: In `ST_ARMED`, if a pending bit is enabled, `irq` rises one cycle later. The transmit bit is masked by the transmit enable, and both the receive and overflow bits are masked by the receive enable. A pending bit that is not enabled never raises `irq`.
- R8: While `irq` is high, a status read drops it on the next cycle. It then stays low, whatever new events arrive, until every status word has been read since firing. After that the machine re-arms and fires again one cycle later if an enabled bit is still pending.
- R9: In `ST_FIRE`, if enable writes leave no enabled pending bit and no status word is read, `irq` falls one cycle later and the machine re-arms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_tx | input | NUM_CH | Transmit-done event pulses, one per channel |
| ev_rx | input | NUM_CH | Receive-done event pulses, one per channel |
| ev_ovf | input | NUM_CH | Receive-overflow event pulses, one per channel |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| irq | output | 1 | Level interrupt request |

## Verification
The bench targets four corner cases.

- **Vectors spanning a word boundary.** Receive and overflow bits for channels that straddle word 0 and word 1 are read back. A design with a wrong packing offset would return those bits in the wrong word or lose them.
- **Event arriving during a read of its own word.** A design that clears after merging would drop that event silently.
- **Masked status word left unread.** Software reads only the status word that holds the enabled cause and skips the other. A design that re-arms early would raise `irq` again before every word was read.
- **Removing the cause by masking.** A design that ignores enable changes in `ST_FIRE` would keep the line high with no enabled cause.

// File: rtl/ring_irq_pkg.sv
package ring_irq_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        ST_ARMED = 2'd0,
        ST_FIRE  = 2'd1,
        ST_DRAIN = 2'd2
    } rearm_state_t;

    function automatic int words_for(input int nbits);
        return (nbits + WORD_W - 1) / WORD_W;
    endfunction

endpackage

// File: rtl/ring_irq_event_store.sv
module ring_irq_event_store
    import ring_irq_pkg::*;
#(
    parameter int NUM_CH    = 20,
    parameter int NUM_WORDS = words_for(3 * NUM_CH)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_CH-1:0]             ev_tx,
    input  logic [NUM_CH-1:0]             ev_rx,
    input  logic [NUM_CH-1:0]             ev_ovf,
    input  logic [NUM_WORDS-1:0]          clr_word,
    output logic [NUM_WORDS*WORD_W-1:0]   pend_flat
);

    localparam int FLAT_W = 3 * NUM_CH;
    localparam int PAD_W  = NUM_WORDS * WORD_W - FLAT_W;

    logic [FLAT_W-1:0] ev_flat;
    logic [FLAT_W-1:0] clr_flat;
    logic [FLAT_W-1:0] pend_q;

    // transmit occupies the low bits, then receive, then overflow
    assign ev_flat = {ev_ovf, ev_rx, ev_tx};

    for (genvar k = 0; k < FLAT_W; k++) begin : g_clr
        assign clr_flat[k] = clr_word[k / WORD_W];
    end

    // clear first, then merge, so a same-cycle event survives the read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_flat) | ev_flat;
    end

    if (PAD_W > 0) begin : g_pad
        assign pend_flat = {{PAD_W{1'b0}}, pend_q};
    end else begin : g_nopad
        assign pend_flat = pend_q;
    end

endmodule

// File: rtl/ring_irq_enable_regs.sv
module ring_irq_enable_regs
    import ring_irq_pkg::*;
#(
    parameter int NUM_CH    = 20,
    parameter int NUM_WORDS = words_for(2 * NUM_CH)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_WORDS-1:0]          wr_word,
    input  logic [WORD_W-1:0]             wdata,
    output logic [NUM_CH-1:0]             en_rx,
    output logic [NUM_CH-1:0]             en_tx,
    output logic [NUM_WORDS*WORD_W-1:0]   en_flat
);

    localparam int FLAT_W = 2 * NUM_CH;
    localparam int PAD_W  = NUM_WORDS * WORD_W - FLAT_W;

    logic [FLAT_W-1:0] wr_flat;
    logic [FLAT_W-1:0] wd_flat;
    logic [FLAT_W-1:0] en_q;

    for (genvar k = 0; k < FLAT_W; k++) begin : g_map
        assign wr_flat[k] = wr_word[k / WORD_W];
        assign wd_flat[k] = wdata[k % WORD_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= (en_q & ~wr_flat) | (wd_flat & wr_flat);
    end

    // receive enables first, transmit enables above them
    assign en_rx = en_q[NUM_CH-1:0];
    assign en_tx = en_q[FLAT_W-1:NUM_CH];

    if (PAD_W > 0) begin : g_pad
        assign en_flat = {{PAD_W{1'b0}}, en_q};
    end else begin : g_nopad
        assign en_flat = en_q;
    end

endmodule

// File: rtl/ring_irq_rearm_fsm.sv
module ring_irq_rearm_fsm
    import ring_irq_pkg::*;
#(
    parameter int NUM_WORDS = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  hit,
    input  logic [NUM_WORDS-1:0]  rd_word,
    output logic                  irq,
    output rearm_state_t          state_o
);

    rearm_state_t         state_q, state_d;
    logic [NUM_WORDS-1:0] seen_q, seen_d;
    logic                 any_rd;

    assign any_rd  = |rd_word;
    assign state_o = state_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        seen_d  = seen_q;
        unique case (state_q)
            ST_ARMED: begin
                seen_d = '0;
                if (hit) state_d = ST_FIRE;
            end
            ST_FIRE: begin
                if (any_rd) begin
                    seen_d  = rd_word;
                    state_d = (&rd_word) ? ST_ARMED : ST_DRAIN;
                end else if (!hit) begin
                    state_d = ST_ARMED;
                end
            end
            ST_DRAIN: begin
                seen_d = seen_q | rd_word;
                if (&seen_d) state_d = ST_ARMED;
            end
            default: begin
                state_d = ST_ARMED;
                seen_d  = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ARMED;
            seen_q  <= '0;
        end else begin
            state_q <= state_d;
            seen_q  <= seen_d;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= (state_d == ST_FIRE);
    end

endmodule

// File: rtl/ring_irq_ctrl.sv
module ring_irq_ctrl
    import ring_irq_pkg::*;
#(
    parameter int NUM_CH    = 20,
    parameter int ADDR_W    = 6,
    parameter int STAT_BASE = 0,
    parameter int EN_BASE   = 16,
    parameter int CAP_ADDR  = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_CH-1:0]   ev_tx,
    input  logic [NUM_CH-1:0]   ev_rx,
    input  logic [NUM_CH-1:0]   ev_ovf,
    input  logic                reg_rd,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    output logic                irq
);

    localparam int NS = words_for(3 * NUM_CH);
    localparam int NE = words_for(2 * NUM_CH);
    localparam logic [31:0] CAP_WORD = 32'(NUM_CH) & 32'h0000_07FF;

    logic [NS-1:0]        stat_rd_word;
    logic [NE-1:0]        en_wr_word;
    logic [NS*WORD_W-1:0] pend_flat;
    logic [NE*WORD_W-1:0] en_flat;
    logic [NUM_CH-1:0]    en_rx, en_tx;
    logic [NUM_CH-1:0]    pend_tx, pend_rx, pend_ovf;
    logic                 hit;
    logic [31:0]          rd_mux;
    rearm_state_t         fsm_state;

    // address decode
    for (genvar w = 0; w < NS; w++) begin : g_sdec
        assign stat_rd_word[w] = reg_rd && (reg_addr == ADDR_W'(STAT_BASE + w));
    end
    for (genvar e = 0; e < NE; e++) begin : g_edec
        assign en_wr_word[e] = reg_wr && (reg_addr == ADDR_W'(EN_BASE + e));
    end

    ring_irq_event_store #(.NUM_CH(NUM_CH), .NUM_WORDS(NS)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_tx    (ev_tx),
        .ev_rx    (ev_rx),
        .ev_ovf   (ev_ovf),
        .clr_word (stat_rd_word),
        .pend_flat(pend_flat)
    );

    ring_irq_enable_regs #(.NUM_CH(NUM_CH), .NUM_WORDS(NE)) u_enable (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_word(en_wr_word),
        .wdata  (reg_wdata),
        .en_rx  (en_rx),
        .en_tx  (en_tx),
        .en_flat(en_flat)
    );

    assign pend_tx  = pend_flat[NUM_CH-1:0];
    assign pend_rx  = pend_flat[2*NUM_CH-1:NUM_CH];
    assign pend_ovf = pend_flat[3*NUM_CH-1:2*NUM_CH];

    // overflow shares the receive mask
    assign hit = |(pend_tx & en_tx) | |(pend_rx & en_rx) | |(pend_ovf & en_rx);

    ring_irq_rearm_fsm #(.NUM_WORDS(NS)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit    (hit),
        .rd_word(stat_rd_word),
        .irq    (irq),
        .state_o(fsm_state)
    );

    // read multiplexer
    always_comb begin
        rd_mux = '0;
        for (int w = 0; w < NS; w++) begin
            if (reg_addr == ADDR_W'(STAT_BASE + w)) rd_mux = pend_flat[w*WORD_W +: WORD_W];
        end
        for (int e = 0; e < NE; e++) begin
            if (reg_addr == ADDR_W'(EN_BASE + e)) rd_mux = en_flat[e*WORD_W +: WORD_W];
        end
        if (reg_addr == ADDR_W'(CAP_ADDR)) rd_mux = CAP_WORD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_mux;
    end

endmodule

// File: rtl/ring_irq_ctrl_chk.sv
module ring_irq_ctrl_chk
    import ring_irq_pkg::*;
#(
    parameter int NUM_CH = 20,
    parameter int NS     = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 irq,
    input rearm_state_t         state,
    input logic [NS*WORD_W-1:0] pend,
    input logic [NUM_CH-1:0]    en_rx,
    input logic [NUM_CH-1:0]    en_tx,
    input logic [NS-1:0]        stat_rd,
    input logic [NUM_CH-1:0]    ev_tx,
    input logic [NUM_CH-1:0]    ev_rx,
    input logic [NUM_CH-1:0]    ev_ovf
);

    localparam int LOW_W = (3 * NUM_CH < WORD_W) ? 3 * NUM_CH : WORD_W;

    logic [3*NUM_CH-1:0] ev_all;
    logic                cause;

    assign ev_all = {ev_ovf, ev_rx, ev_tx};
    assign cause  = |(pend[NUM_CH-1:0] & en_tx)
                  | |(pend[2*NUM_CH-1:NUM_CH] & en_rx)
                  | |(pend[3*NUM_CH-1:2*NUM_CH] & en_rx);

    a_r7_needs_cause: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(cause));

    a_r7_fires: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && cause) |=> irq);

    a_r8_drop_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && |stat_rd) |=> !irq);

    a_r8_drain_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN && stat_rd == '0) |=> !irq);

    a_r9_mask_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !cause && stat_rd == '0) |=> !irq);

    a_r3_word0_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd[0] && ev_all[LOW_W-1:0] == '0) |=> (pend[LOW_W-1:0] == '0));

    a_r4_keep_event: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd[0] && ev_all[0]) |=> pend[0]);

endmodule

bind ring_irq_ctrl ring_irq_ctrl_chk #(.NUM_CH(NUM_CH), .NS(NS)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .irq    (irq),
    .state  (fsm_state),
    .pend   (pend_flat),
    .en_rx  (en_rx),
    .en_tx  (en_tx),
    .stat_rd(stat_rd_word),
    .ev_tx  (ev_tx),
    .ev_rx  (ev_rx),
    .ev_ovf (ev_ovf)
);

// File: tb/ring_irq_ctrl_bench.sv
`timescale 1ns/1ps
module ring_irq_ctrl_bench;

    localparam int N   = 20;
    localparam int NSW = (31 + 3 * N) / 32;
    localparam int NEW = (31 + 2 * N) / 32;
    localparam int EB  = 16;
    localparam int CA  = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [N-1:0] ev_tx = '0, ev_rx = '0, ev_ovf = '0;
    logic        reg_rd = 1'b0, reg_wr = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    ring_irq_ctrl u_ring_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .ev_tx(ev_tx), .ev_rx(ev_rx), .ev_ovf(ev_ovf),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    // behavioural reference model
    bit [63:0] m_pend, m_en;
    int        m_state, m_seen;
    bit        m_irq, m_rvalid;
    bit [31:0] m_rdata;
    string     m_rtag;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pend = '0; m_en = '0; m_state = 0; m_seen = 0;
            m_irq = 0; m_rvalid = 0; m_rdata = '0;
        end else begin
            int a, sr;
            bit hit, evb;
            bit [31:0] w;
            a = int'(reg_addr);
            hit = 0;
            for (int i = 0; i < N; i++)
                hit |= (m_pend[i] & m_en[N+i]) | (m_pend[N+i] & m_en[i]) | (m_pend[2*N+i] & m_en[i]);
            m_rvalid = reg_rd;
            if (reg_rd) begin
                w = '0; m_rtag = "R6";
                if (a < NSW) begin
                    m_rtag = "R3";
                    for (int b = 0; b < 32; b++) if (a*32+b < 3*N) w[b] = m_pend[a*32+b];
                end else if (a >= EB && a < EB + NEW) begin
                    m_rtag = "R5";
                    for (int b = 0; b < 32; b++) if ((a-EB)*32+b < 2*N) w[b] = m_en[(a-EB)*32+b];
                end else if (a == CA) w = N;
                m_rdata = w;
            end
            sr = (reg_rd && a < NSW) ? (1 << a) : 0;
            for (int k = 0; k < 3*N; k++) begin
                if (sr[k/32]) m_pend[k] = 0;
                evb = (k < N) ? ev_tx[k] : (k < 2*N) ? ev_rx[k-N] : ev_ovf[k-2*N];
                m_pend[k] = m_pend[k] | evb;
            end
            if (reg_wr && a >= EB && a < EB + NEW)
                for (int b = 0; b < 32; b++) if ((a-EB)*32+b < 2*N) m_en[(a-EB)*32+b] = reg_wdata[b];
            case (m_state)
                0: if (hit) m_state = 1;
                1: if (sr != 0) begin
                       m_seen = sr;
                       m_state = (m_seen == (1 << NSW) - 1) ? 0 : 2;
                   end else if (!hit) m_state = 0;
                default: begin
                       m_seen |= sr;
                       if (m_seen == (1 << NSW) - 1) m_state = 0;
                   end
            endcase
            m_irq = (m_state == 1);
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one cycle: sample away from the edge, compare with the model, release strobes
    task automatic tick();
        @(negedge clk);
        if (rst_n) begin
            check("R7/R8/R9 irq vs model", {31'b0, irq}, {31'b0, m_irq});
            if (m_rvalid) check({m_rtag, " rdata vs model"}, reg_rdata, m_rdata);
        end
        reg_rd = 0; reg_wr = 0; ev_tx = '0; ev_rx = '0; ev_ovf = '0;
    endtask

    task automatic rd(int a);
        reg_rd = 1; reg_addr = 6'(a); tick();
    endtask

    task automatic wr(int a, logic [31:0] d);
        reg_wr = 1; reg_addr = 6'(a); reg_wdata = d; tick();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (4) tick();
        rst_n = 1;
        tick();
        // R1 reset state
        check("R1 irq after reset", {31'b0, irq}, 32'h0);
        rd(0);  check("R1 status0 zero", reg_rdata, 32'h0);
        rd(1);  check("R1 status1 zero", reg_rdata, 32'h0);
        rd(EB); check("R1 enable zero", reg_rdata, 32'h0);
        // R6 capability, read-only, unmapped
        rd(CA); check("R6 capability", reg_rdata, 32'd20);
        wr(CA, 32'hFFFF_FFFF);
        rd(CA); check("R6 capability after write", reg_rdata, 32'd20);
        rd(5);  check("R6 unmapped reads zero", reg_rdata, 32'h0);
        // R5 enable packing and readback
        wr(EB, 32'hFFFF_FFFF);   rd(EB);   check("R5 enable word0", reg_rdata, 32'hFFFF_FFFF);
        wr(EB+1, 32'hFFFF_FFFF); rd(EB+1); check("R5 enable word1 tail", reg_rdata, 32'h0000_00FF);
        wr(EB, 0); wr(EB+1, 0);
        // R7 disabled event never interrupts; R3 clear on read
        ev_tx[3] = 1; tick(); tick(); tick();
        check("R7 masked no irq", {31'b0, irq}, 32'h0);
        rd(0); check("R3 read returns pending", reg_rdata, 32'h0000_0008);
        rd(0); check("R3 read cleared", reg_rdata, 32'h0);
        // R2 vectors straddling words
        ev_rx[11] = 1; ev_rx[15] = 1; ev_ovf[19] = 1; tick();
        rd(1); check("R2 word1 layout", reg_rdata, 32'h0800_0008);
        rd(0); check("R2 word0 layout", reg_rdata, 32'h8000_0000);
        // R4 event during read of its word
        ev_tx[2] = 1; reg_rd = 1; reg_addr = 0; tick();
        check("R4 read excludes same-cycle event", reg_rdata, 32'h0);
        rd(0); check("R4 event kept", reg_rdata, 32'h0000_0004);
        // R6 write to status ignored
        ev_tx[0] = 1; tick();
        wr(0, 32'h0);
        rd(0); check("R6 status write ignored", reg_rdata, 32'h0000_0001);
        // R7/R8: transmit channel 5 enabled (flat enable bit 25)
        wr(EB, 32'h0200_0000);
        ev_tx[5] = 1; tick();
        tick(); check("R7 irq raised", {31'b0, irq}, 32'h1);
        rd(0); check("R8 irq dropped on read", {31'b0, irq}, 32'h0);
        ev_tx[5] = 1; tick(); tick(); tick();
        check("R8 held low until all words read", {31'b0, irq}, 32'h0);
        rd(1); check("R8 re-arm cycle", {31'b0, irq}, 32'h0);
        tick(); check("R8 fires again after full drain", {31'b0, irq}, 32'h1);
        rd(0); rd(1); tick(); tick();
        check("R8 quiet after drain", {31'b0, irq}, 32'h0);
        // R7 overflow masked by receive enable, R9 unmask drop
        wr(EB, 32'h0000_0010);
        ev_ovf[4] = 1; tick(); tick();
        check("R7 overflow via rx enable", {31'b0, irq}, 32'h1);
        wr(EB, 32'h0); tick();
        check("R9 irq drops when masked", {31'b0, irq}, 32'h0);
        wr(EB, 32'h0000_0010); tick();
        check("R9 re-armed fires again", {31'b0, irq}, 32'h1);
        rd(0); rd(1); wr(EB, 32'h0);
        // mixed traffic against the model
        for (int c = 0; c < 2000; c++) begin
            for (int i = 0; i < N; i++) begin
                ev_tx[i]  = ($urandom % 24) == 0;
                ev_rx[i]  = ($urandom % 24) == 0;
                ev_ovf[i] = ($urandom % 40) == 0;
            end
            case ($urandom % 8)
                0: begin reg_rd = 1; reg_addr = 0; end
                1: begin reg_rd = 1; reg_addr = 1; end
                2: begin reg_wr = 1; reg_addr = 6'(EB); reg_wdata = $urandom & $urandom; end
                3: begin reg_wr = 1; reg_addr = 6'(EB+1); reg_wdata = $urandom; end
                4: begin reg_rd = 1; reg_addr = 6'($urandom % 40); end
                default: ;
            endcase
            tick();
        end
        finish_run();
    end

endmodule